// File: doc/BRIEF.md
# Write-Through Sectored Data Cache

This block is a direct-mapped data cache of 16 lines, each line holding four 32-bit words. Every word carries its own valid bit. Every line tag stores the 3-bit function code of the access together with the upper address bits. The CPU side issues one request at a time: address, function code, read/write flag, write data, byte enables, a translation-table-search marker, an MMU fault flag and a freeze flag. Each request is answered by a one-cycle done pulse that carries read data, a hit flag and a bus-error flag.

Reads that hit are served from the array and make no memory traffic. Read misses go to memory. The memory read is either a four-beat line burst or a single word. The single-word read refills only the missing word of a line that is already partly valid. Writes always go through to memory. A write hit first updates the cached word, and it does so even while the cache is frozen. A write rejected by the MMU makes no memory cycle, invalidates the matching word and reports a bus error. Accesses in CPU space and translation-table searches bypass the array entirely.

Top module: `wtDataCache`

## Requirements
- R1: A lookup hits only when the line selected by address bits 7:4 holds a tag equal to the request's function code and address bits 31:8, and the valid bit chosen by address bits 3:2 is set. The same address with a different function code misses.
- R2: After reset, and one cycle after `clearAll` is high, every valid bit is zero, so the next read of a previously cached word misses.
- R3: A request with function code 7, or with `cpuTableSearch` high, never reports a hit. It reads memory with a single non-burst cycle and changes no tag, valid bit or cached word.
- R4: A cachable read hit answers with `cpuHit`=1 and the cached word, and issues no memory request.
- R5: A cachable, unfrozen read miss on a line whose tag differs, or whose four valid bits are all clear, issues a burst (`memBurst`=1) at the line base address. The bench returns four beats for words 0,1,2,3 in that order. All four words become valid under the new tag, and the requested word is returned with `cpuHit`=0.
- R6: A cachable, unfrozen read miss on a line whose tag matches and which has another word valid issues one non-burst read at the word address, and makes only that word valid.
- R7: A write that is not rejected by the MMU issues exactly one external write with the request's data and byte enables. On a hit, it also merges the enabled bytes into the cached word, whether or not `freeze` is high.
- R8: A write miss does not allocate, and the next read of that address misses. The write response's `cpuHit` equals whether the write hit.
- R9: A write with `mmuFault` high issues no memory request. It answers with `cpuBusErr`=1 and `cpuHit`=0, and clears the valid bit of the addressed word when the tag matches.
- R10: When the external write of a write hit ends with `memBusErr`, the response has `cpuBusErr`=1, and the cache keeps the new bytes, so a later read hits with them.
- R11: A read miss with `freeze` high uses a single non-burst read and changes no tag or valid bit.
- R12: `cpuReq` is accepted only while idle. `cpuDone` is a one-cycle pulse per request. `memReq` and `memAddr` hold steady until `memAck`, and each `memAck` transfers one beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| clearAll | input | 1 | Synchronous clear of every valid bit |
| freeze | input | 1 | Sampled with the request; frozen reads allocate nothing |
| cpuReq | input | 1 | Request strobe, one cycle, while idle |
| cpuWrite | input | 1 | 1 for write, 0 for read |
| cpuAddr | input | 32 | Byte address |
| cpuFc | input | 3 | Function code |
| cpuTableSearch | input | 1 | Access is a translation-table search |
| cpuWdata | input | 32 | Write data |
| cpuBe | input | 4 | Byte enables of the write |
| mmuFault | input | 1 | MMU rejects this write |
| cpuDone | output | 1 | One-cycle response pulse |
| cpuRdata | output | 32 | Read data |
| cpuHit | output | 1 | Request hit the cache |
| cpuBusErr | output | 1 | Request ended in a bus error |
| memReq | output | 1 | Memory request, held until the last beat |
| memWrite | output | 1 | Memory request is a write |
| memBurst | output | 1 | Four-beat line read |
| memAddr | output | 32 | Word address, or line base address for a burst |
| memWdata | output | 32 | Write data to memory |
| memBe | output | 4 | Byte enables to memory |
| memAck | input | 1 | One beat is complete |
| memRdata | input | 32 | Read beat data |
| memBusErr | input | 1 | Beat ended in a bus error |

## Verification
The assertions check the bus-level rules on every cycle. They confirm that `cpuDone` is a single pulse inside a request, that a pending memory request holds its address, that a faulted write never reaches memory, that a bypassed access never bursts, and that a burst is line-aligned and never a write. Only the bench's scenarios can show what the array remembers: hits after fills, the burst-versus-single choice on a partly valid line, invalidation on a fault, kept data after a write bus error, and the absence of allocation on frozen reads, on write misses and after a clear.

// File: rtl/wtDataCachePkg.sv
package wtDataCachePkg;
  typedef struct packed {
    logic tagLoad;   // install tag, clear the line's valid bits
    logic wordLoad;  // write enabled bytes of one word, mark it valid
    logic wordKill;  // clear one word's valid bit
    logic clearAll;  // clear every valid bit
  } dcStrobe_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LOOKUP, ST_MEMRD, ST_MEMWR, ST_RESP
  } dcState_t;
endpackage

// File: rtl/wtDataCacheArray.sv
module wtDataCacheArray
  import wtDataCachePkg::*;
#(
  parameter int LINES  = 16,
  parameter int WORDS  = 4,
  parameter int DATA_W = 32,
  parameter int TAGF_W = 27,
  localparam int BYTES  = DATA_W / 8,
  localparam int IDX_W  = $clog2(LINES),
  localparam int WSEL_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  dcStrobe_t         stb,
  input  logic [IDX_W-1:0]  lineIdx,
  input  logic [WSEL_W-1:0] wordSel,
  input  logic [TAGF_W-1:0] tagIn,
  input  logic [DATA_W-1:0] wrData,
  input  logic [BYTES-1:0]  wrBe,
  output logic              tagMatch,
  output logic              wordValid,
  output logic              anyValid,
  output logic [DATA_W-1:0] rdWord
);
  logic [LINES-1:0][TAGF_W-1:0] tagMem;
  logic [LINES-1:0][WORDS-1:0]  validMem;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tagMem   <= '0;
      validMem <= '0;
    end else if (stb.clearAll) begin
      validMem <= '0;
    end else begin
      if (stb.tagLoad) begin
        tagMem[lineIdx]   <= tagIn;
        validMem[lineIdx] <= '0;
      end
      if (stb.wordLoad) validMem[lineIdx][wordSel] <= 1'b1;
      if (stb.wordKill) validMem[lineIdx][wordSel] <= 1'b0;
    end
  end

  for (genvar b = 0; b < BYTES; b++) begin : gLane
    logic [7:0] laneMem [LINES][WORDS];
    always_ff @(posedge clk) begin
      if (stb.wordLoad && wrBe[b]) laneMem[lineIdx][wordSel] <= wrData[8*b +: 8];
    end
    assign rdWord[8*b +: 8] = laneMem[lineIdx][wordSel];
  end

  assign tagMatch  = (tagMem[lineIdx] == tagIn);
  assign wordValid = validMem[lineIdx][wordSel];
  assign anyValid  = |validMem[lineIdx];
endmodule

// File: rtl/wtDataCacheCtrl.sv
module wtDataCacheCtrl
  import wtDataCachePkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int FC_W   = 3,
  parameter int LINES  = 16,
  parameter int WORDS  = 4,
  parameter logic [2:0] CPU_FC = 3'd7,
  localparam int BYTES  = DATA_W / 8,
  localparam int OFF_W  = $clog2(BYTES),
  localparam int WSEL_W = $clog2(WORDS),
  localparam int IDX_W  = $clog2(LINES),
  localparam int ATAG_W = ADDR_W - IDX_W - WSEL_W - OFF_W,
  localparam int TAGF_W = ATAG_W + FC_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clearAll,
  input  logic              freeze,
  input  logic              cpuReq,
  input  logic              cpuWrite,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [FC_W-1:0]   cpuFc,
  input  logic              cpuTableSearch,
  input  logic [DATA_W-1:0] cpuWdata,
  input  logic [BYTES-1:0]  cpuBe,
  input  logic              mmuFault,
  output logic              cpuDone,
  output logic [DATA_W-1:0] cpuRdata,
  output logic              cpuHit,
  output logic              cpuBusErr,
  output logic              memReq,
  output logic              memWrite,
  output logic              memBurst,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic [BYTES-1:0]  memBe,
  input  logic              memAck,
  input  logic [DATA_W-1:0] memRdata,
  input  logic              memBusErr,
  // array side
  output dcStrobe_t         stb,
  output logic [IDX_W-1:0]  lineIdx,
  output logic [WSEL_W-1:0] wordSel,
  output logic [TAGF_W-1:0] tagIn,
  output logic [DATA_W-1:0] wrData,
  output logic [BYTES-1:0]  wrBe,
  input  logic              tagMatch,
  input  logic              wordValid,
  input  logic              anyValid,
  input  logic [DATA_W-1:0] rdWord
);
  localparam logic [ADDR_W-1:0] WORD_MASK = ~ADDR_W'((1 << OFF_W) - 1);
  localparam logic [ADDR_W-1:0] LINE_MASK = ~ADDR_W'((1 << (OFF_W + WSEL_W)) - 1);

  dcState_t          state;
  logic [ADDR_W-1:0] rAddr;
  logic [FC_W-1:0]   rFc;
  logic [DATA_W-1:0] rWdata;
  logic [BYTES-1:0]  rBe;
  logic              rWrite, rNoCache, rFault, rFreeze, rBurst, rFill;
  logic [WSEL_W-1:0] beat;
  logic [DATA_W-1:0] respData;
  logic              respHit, respErr;

  logic [WSEL_W-1:0] reqWord;
  logic              lineHit, wantBurst, lastBeat;

  assign reqWord   = rAddr[OFF_W +: WSEL_W];
  assign lineIdx   = rAddr[OFF_W + WSEL_W +: IDX_W];
  assign tagIn     = {rFc, rAddr[ADDR_W-1 -: ATAG_W]};
  assign lineHit   = !rNoCache && tagMatch && wordValid;
  assign wantBurst = !rNoCache && !rFreeze && !(tagMatch && anyValid);
  assign lastBeat  = !rBurst || (beat == WSEL_W'(WORDS - 1));

  always_comb begin
    wordSel = (state == ST_MEMRD && rBurst) ? beat : reqWord;
    wrData  = (state == ST_MEMRD) ? memRdata : rWdata;
    wrBe    = (state == ST_MEMRD) ? '1 : rBe;
  end

  always_comb begin
    stb          = '0;
    stb.clearAll = clearAll;
    case (state)
      ST_LOOKUP: begin
        if (rWrite) begin
          if (rFault) stb.wordKill = !rNoCache && tagMatch;
          else        stb.wordLoad = lineHit;
        end else if (!lineHit) begin
          stb.tagLoad = wantBurst;
        end
      end
      ST_MEMRD: stb.wordLoad = memAck && !memBusErr && rFill;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      rAddr    <= '0;
      rFc      <= '0;
      rWdata   <= '0;
      rBe      <= '0;
      rWrite   <= 1'b0;
      rNoCache <= 1'b0;
      rFault   <= 1'b0;
      rFreeze  <= 1'b0;
      rBurst   <= 1'b0;
      rFill    <= 1'b0;
      beat     <= '0;
      respData <= '0;
      respHit  <= 1'b0;
      respErr  <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (cpuReq) begin
          rAddr    <= cpuAddr;
          rFc      <= cpuFc;
          rWdata   <= cpuWdata;
          rBe      <= cpuBe;
          rWrite   <= cpuWrite;
          rNoCache <= (cpuFc == CPU_FC) || cpuTableSearch;
          rFault   <= mmuFault;
          rFreeze  <= freeze;
          respErr  <= 1'b0;
          respHit  <= 1'b0;
          state    <= ST_LOOKUP;
        end
        ST_LOOKUP: begin
          if (rWrite) begin
            if (rFault) begin
              respErr <= 1'b1;
              state   <= ST_RESP;
            end else begin
              respHit <= lineHit;
              state   <= ST_MEMWR;
            end
          end else if (lineHit) begin
            respData <= rdWord;
            respHit  <= 1'b1;
            state    <= ST_RESP;
          end else begin
            rBurst <= wantBurst;
            rFill  <= !rNoCache && !rFreeze;
            beat   <= '0;
            state  <= ST_MEMRD;
          end
        end
        ST_MEMRD: if (memAck) begin
          if (memBusErr) begin
            respErr <= 1'b1;
            state   <= ST_RESP;
          end else begin
            if (!rBurst || beat == reqWord) respData <= memRdata;
            beat <= beat + 1'b1;
            if (lastBeat) state <= ST_RESP;
          end
        end
        ST_MEMWR: if (memAck) begin
          respErr <= memBusErr;
          state   <= ST_RESP;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign cpuDone   = (state == ST_RESP);
  assign cpuRdata  = respData;
  assign cpuHit    = respHit;
  assign cpuBusErr = respErr;
  assign memReq    = (state == ST_MEMRD) || (state == ST_MEMWR);
  assign memWrite  = (state == ST_MEMWR);
  assign memBurst  = (state == ST_MEMRD) && rBurst;
  assign memAddr   = rAddr & (memBurst ? LINE_MASK : WORD_MASK);
  assign memWdata  = rWdata;
  assign memBe     = memWrite ? rBe : '1;
endmodule

// File: rtl/wtDataCache.sv
module wtDataCache
  import wtDataCachePkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int FC_W   = 3,
  parameter int LINES  = 16,
  parameter int WORDS  = 4,
  localparam int BYTES  = DATA_W / 8,
  localparam int OFF_W  = $clog2(BYTES),
  localparam int WSEL_W = $clog2(WORDS),
  localparam int IDX_W  = $clog2(LINES),
  localparam int TAGF_W = ADDR_W - IDX_W - WSEL_W - OFF_W + FC_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clearAll,
  input  logic              freeze,
  input  logic              cpuReq,
  input  logic              cpuWrite,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [FC_W-1:0]   cpuFc,
  input  logic              cpuTableSearch,
  input  logic [DATA_W-1:0] cpuWdata,
  input  logic [BYTES-1:0]  cpuBe,
  input  logic              mmuFault,
  output logic              cpuDone,
  output logic [DATA_W-1:0] cpuRdata,
  output logic              cpuHit,
  output logic              cpuBusErr,
  output logic              memReq,
  output logic              memWrite,
  output logic              memBurst,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic [BYTES-1:0]  memBe,
  input  logic              memAck,
  input  logic [DATA_W-1:0] memRdata,
  input  logic              memBusErr
);
  dcStrobe_t         stb;
  logic [IDX_W-1:0]  lineIdx;
  logic [WSEL_W-1:0] wordSel;
  logic [TAGF_W-1:0] tagIn;
  logic [DATA_W-1:0] wrData, rdWord;
  logic [BYTES-1:0]  wrBe;
  logic              tagMatch, wordValid, anyValid;

  wtDataCacheCtrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .FC_W(FC_W), .LINES(LINES), .WORDS(WORDS)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .clearAll(clearAll), .freeze(freeze),
    .cpuReq(cpuReq), .cpuWrite(cpuWrite), .cpuAddr(cpuAddr), .cpuFc(cpuFc),
    .cpuTableSearch(cpuTableSearch), .cpuWdata(cpuWdata), .cpuBe(cpuBe),
    .mmuFault(mmuFault), .cpuDone(cpuDone), .cpuRdata(cpuRdata),
    .cpuHit(cpuHit), .cpuBusErr(cpuBusErr), .memReq(memReq),
    .memWrite(memWrite), .memBurst(memBurst), .memAddr(memAddr),
    .memWdata(memWdata), .memBe(memBe), .memAck(memAck),
    .memRdata(memRdata), .memBusErr(memBusErr),
    .stb(stb), .lineIdx(lineIdx), .wordSel(wordSel), .tagIn(tagIn),
    .wrData(wrData), .wrBe(wrBe), .tagMatch(tagMatch),
    .wordValid(wordValid), .anyValid(anyValid), .rdWord(rdWord)
  );

  wtDataCacheArray #(
    .LINES(LINES), .WORDS(WORDS), .DATA_W(DATA_W), .TAGF_W(TAGF_W)
  ) uArray (
    .clk(clk), .rstN(rstN), .stb(stb), .lineIdx(lineIdx), .wordSel(wordSel),
    .tagIn(tagIn), .wrData(wrData), .wrBe(wrBe), .tagMatch(tagMatch),
    .wordValid(wordValid), .anyValid(anyValid), .rdWord(rdWord)
  );
endmodule

// File: rtl/wtDataCacheChk.sv
module wtDataCacheChk (
  input logic        clk,
  input logic        rstN,
  input logic        cpuReq,
  input logic        cpuWrite,
  input logic [2:0]  cpuFc,
  input logic        cpuTableSearch,
  input logic        mmuFault,
  input logic        cpuDone,
  input logic        memReq,
  input logic        memWrite,
  input logic        memBurst,
  input logic [31:0] memAddr,
  input logic        memAck
);
  logic busy, pendFault, pendBypass;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy       <= 1'b0;
      pendFault  <= 1'b0;
      pendBypass <= 1'b0;
    end else if (!busy && cpuReq) begin
      busy       <= 1'b1;
      pendFault  <= cpuWrite && mmuFault;
      pendBypass <= (cpuFc == 3'd7) || cpuTableSearch;
    end else if (cpuDone) begin
      busy <= 1'b0;
    end
  end

  p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rstN)
    cpuDone |=> !cpuDone);
  p_done_in_req_r12: assert property (@(posedge clk) disable iff (!rstN)
    cpuDone |-> busy);
  p_req_hold_r12: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck |=> memReq && $stable(memAddr) && $stable(memWrite));
  p_fault_no_mem_r9: assert property (@(posedge clk) disable iff (!rstN)
    busy && pendFault |-> !memReq);
  p_bypass_single_r3: assert property (@(posedge clk) disable iff (!rstN)
    busy && pendBypass && memReq |-> !memBurst);
  p_burst_aligned_r5: assert property (@(posedge clk) disable iff (!rstN)
    memReq && memBurst |-> (memAddr[3:0] == 4'd0) && !memWrite);
endmodule

bind wtDataCache wtDataCacheChk uChk (.*);

// File: tb/tb_wtDataCache.sv
`timescale 1ns/1ps
module tb_wtDataCache;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic clearAll = 0, freeze = 0, cpuReq = 0, cpuWrite = 0, cpuTableSearch = 0, mmuFault = 0;
  logic [31:0] cpuAddr = 0, cpuWdata = 0;
  logic [2:0]  cpuFc = 0;
  logic [3:0]  cpuBe = 0;
  logic cpuDone, cpuHit, cpuBusErr, memReq, memWrite, memBurst;
  logic [31:0] cpuRdata, memAddr, memWdata;
  logic [3:0]  memBe;
  logic memAck = 0, memBusErr = 0;
  logic [31:0] memRdata = 0;

  always #5 clk = ~clk;

  wtDataCache dut (.*);

  int nChecks = 0, nFails = 0;
  bit finished = 0;

  // environment memory
  logic [31:0] memStore [logic [31:0]];
  bit injectErr = 0;
  bit lastBurst;
  logic [31:0] lastMemAddr, lastWdata;
  logic [3:0] lastBe;
  int rdCnt = 0, wrCnt = 0;

  // reference cache model
  bit          mVal [16][4];
  logic [26:0] mTag [16];
  logic [31:0] mData [16][4];

  function automatic logic [31:0] memRead(logic [31:0] a);
    if (memStore.exists(a)) return memStore[a];
    return {a[15:0] ^ 16'hC3A5, a[31:16] ^ 16'h1E0F};
  endfunction

  function automatic logic [31:0] merge(logic [31:0] old, logic [31:0] nw, logic [3:0] be);
    logic [31:0] r = old;
    for (int b = 0; b < 4; b++) if (be[b]) r[8*b +: 8] = nw[8*b +: 8];
    return r;
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory responder
  initial begin
    forever begin
      @(negedge clk);
      if (memReq) begin
        automatic int n = memBurst ? 4 : 1;
        automatic logic [31:0] base = memAddr;
        automatic bit wr = memWrite;
        lastBurst = memBurst; lastMemAddr = memAddr;
        if (wr) begin wrCnt++; lastWdata = memWdata; lastBe = memBe; end
        else rdCnt++;
        for (int k = 0; k < n; k++) begin
          memAck = 1'b1;
          memRdata = memRead(base + 32'(4 * k));
          memBusErr = wr && injectErr;
          if (wr && !injectErr) memStore[base] = merge(memRead(base), memWdata, memBe);
          @(negedge clk);
        end
        memAck = 1'b0; memBusErr = 1'b0;
      end
    end
  end

  task automatic doClear();
    @(negedge clk); clearAll = 1'b1;
    @(negedge clk); clearAll = 1'b0;
    for (int i = 0; i < 16; i++) for (int w = 0; w < 4; w++) mVal[i][w] = 0;
  endtask

  task automatic op(bit wr, logic [31:0] addr, logic [2:0] fc, bit ts, logic [31:0] wd,
                    logic [3:0] be, bit fault, bit frz, bit berr, output logic [31:0] rd);
    automatic int i = int'(addr[7:4]);
    automatic int w = int'(addr[3:2]);
    automatic bit nc = (fc == 3'd7) || ts;
    automatic bit tm = (mTag[i] == {fc, addr[31:8]});
    automatic bit anyV = mVal[i][0] | mVal[i][1] | mVal[i][2] | mVal[i][3];
    automatic bit hitE = !nc && tm && mVal[i][w];
    automatic bit burstE = !nc && !frz && !(tm && anyV);
    automatic logic [31:0] wa = {addr[31:2], 2'b00};
    automatic logic [31:0] expRd = hitE ? mData[i][w] : memRead(wa);
    automatic int rd0 = rdCnt, wr0 = wrCnt;
    @(negedge clk);
    chk(!cpuDone, "R12 done idle", 32'(cpuDone), 0);
    injectErr = berr;
    cpuReq = 1; cpuWrite = wr; cpuAddr = addr; cpuFc = fc; cpuTableSearch = ts;
    cpuWdata = wd; cpuBe = be; mmuFault = fault; freeze = frz;
    @(negedge clk);
    cpuReq = 0;
    do @(negedge clk); while (!cpuDone);
    rd = cpuRdata;
    if (!wr) begin
      if (hitE) begin
        chk(cpuHit == 1, "R4 hit flag", 32'(cpuHit), 1);
        chk(cpuRdata == expRd, "R4 hit data", cpuRdata, expRd);
        chk(rdCnt == rd0, "R4 no memory read", 32'(rdCnt - rd0), 0);
      end else begin
        chk(cpuHit == 0, "R1 miss flag", 32'(cpuHit), 0);
        chk(cpuRdata == expRd, "R5 miss data", cpuRdata, expRd);
        chk(rdCnt == rd0 + 1 && lastBurst == burstE,
            burstE ? "R5 burst" : (nc ? "R3 bypass single" : (frz ? "R11 frozen single" : "R6 single fill")),
            32'(lastBurst), 32'(burstE));
        chk(lastMemAddr == (burstE ? {addr[31:4], 4'h0} : wa), "R5 R6 read address", lastMemAddr,
            burstE ? {addr[31:4], 4'h0} : wa);
        if (burstE) begin
          mTag[i] = {fc, addr[31:8]};
          for (int k = 0; k < 4; k++) begin
            mVal[i][k] = 1; mData[i][k] = memRead({addr[31:4], 4'h0} + 32'(4 * k));
          end
        end else if (!nc && !frz) begin
          mVal[i][w] = 1; mData[i][w] = expRd;
        end
      end
    end else if (fault) begin
      chk(cpuBusErr == 1 && cpuHit == 0, "R9 fault response", {cpuBusErr, cpuHit}, 2);
      chk(wrCnt == wr0, "R9 no external write", 32'(wrCnt - wr0), 0);
      if (!nc && tm) mVal[i][w] = 0;
    end else begin
      chk(wrCnt == wr0 + 1 && lastWdata == wd && lastBe == be, "R7 external write", lastWdata, wd);
      chk(cpuBusErr == berr, "R10 write error flag", 32'(cpuBusErr), 32'(berr));
      chk(cpuHit == hitE, "R8 write hit flag", 32'(cpuHit), 32'(hitE));
      if (hitE) mData[i][w] = merge(mData[i][w], wd, be);
    end
    injectErr = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 16; i++) begin
      mTag[i] = '0;
      for (int w = 0; w < 4; w++) begin mVal[i][w] = 0; mData[i][w] = '0; end
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(cpuDone == 0 && memReq == 0, "R2 reset outputs", {cpuDone, memReq}, 0);

    // R5 first fill, then R4 hit
    op(0, 32'h0000_1234, 3'd1, 0, 0, 0, 0, 0, 0, rd);
    op(0, 32'h0000_1238, 3'd1, 0, 0, 0, 0, 0, 0, rd);
    chk(cpuHit == 1, "R5 line filled", 32'(cpuHit), 1);
    // R1 other function code misses
    op(0, 32'h0000_1238, 3'd5, 0, 0, 0, 0, 0, 0, rd);
    chk(cpuHit == 0, "R1 fc differs", 32'(cpuHit), 0);
    // R9 fault kills word, R6 single refill
    op(1, 32'h0000_1234, 3'd5, 0, 32'hDEAD_BEEF, 4'hF, 1, 0, 0, rd);
    op(0, 32'h0000_1234, 3'd5, 0, 0, 0, 0, 0, 0, rd);
    chk(cpuHit == 0 && lastBurst == 0, "R6 single after fault", {cpuHit, lastBurst}, 0);
    // R7 frozen write hit, then R10 error keeps value
    op(1, 32'h0000_1230, 3'd5, 0, 32'hA1B2_C3D4, 4'b0101, 0, 1, 0, rd);
    op(0, 32'h0000_1230, 3'd5, 0, 0, 0, 0, 1, 0, rd);
    op(1, 32'h0000_123C, 3'd5, 0, 32'h5566_7788, 4'hF, 0, 0, 1, rd);
    op(0, 32'h0000_123C, 3'd5, 0, 0, 0, 0, 0, 0, rd);
    chk(rd == 32'h5566_7788, "R10 kept value", rd, 32'h5566_7788);
    // R8 write miss no allocate
    op(1, 32'h0000_4560, 3'd1, 0, 32'h0BAD_F00D, 4'hF, 0, 0, 0, rd);
    op(0, 32'h0000_4560, 3'd1, 0, 0, 0, 0, 1, 0, rd);
    chk(cpuHit == 0, "R8 no allocation", 32'(cpuHit), 0);
    // R11 frozen miss stays a miss
    op(0, 32'h0000_4560, 3'd1, 0, 0, 0, 0, 0, 0, rd);
    chk(lastBurst == 1, "R11 no tag change", 32'(lastBurst), 1);
    // R3 CPU space and table search bypass
    op(0, 32'h0000_7770, 3'd7, 0, 0, 0, 0, 0, 0, rd);
    op(0, 32'h0000_7770, 3'd7, 0, 0, 0, 0, 0, 0, rd);
    chk(cpuHit == 0, "R3 cpu space never hits", 32'(cpuHit), 0);
    op(0, 32'h0000_7780, 3'd2, 1, 0, 0, 0, 0, 0, rd);
    op(0, 32'h0000_7780, 3'd2, 0, 0, 0, 0, 0, 0, rd);
    chk(lastBurst == 1, "R3 table search left no line", 32'(lastBurst), 1);
    // R2 clear all
    doClear();
    op(0, 32'h0000_1238, 3'd1, 0, 0, 0, 0, 0, 0, rd);
    chk(cpuHit == 0, "R2 cleared", 32'(cpuHit), 0);

    // random traffic
    for (int n = 0; n < 800; n++) begin
      automatic bit wr = ($urandom % 3) == 0;
      automatic logic [31:0] a = {22'h0, 2'($urandom % 2), 4'($urandom % 6), 2'($urandom), 2'b00} + 32'h0001_0000;
      automatic int r = $urandom % 16;
      automatic logic [2:0] fc = (r < 13) ? ((r % 2) ? 3'd1 : 3'd5) : ((r == 13) ? 3'd7 : 3'd2);
      automatic bit ts = ($urandom % 20) == 0;
      automatic bit flt = wr && (($urandom % 10) == 0);
      automatic bit be = wr && !flt && (($urandom % 10) == 0);
      automatic bit frz = ($urandom % 6) == 0;
      if (($urandom % 60) == 0) doClear();
      op(wr, a, fc, ts, $urandom, 4'($urandom), flt, frz, be, rd);
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule